// File: doc/BRIEF.md
# Configurable right shift register

This block is an N-bit register that, on its active clock edge, either takes a parallel word or moves its contents one place toward the least significant end. On a shift the bit at the LSB end is lost and the serial data input becomes the new MSB. An enable input freezes the register when it is inactive. Two override inputs, one forcing a set value and one forcing a reset value, take priority over enable, load and shift.

Build-time parameters choose the active clock edge, which level of the load/shift select means "load", the active level of the override inputs, and whether the overrides act on the clock edge or at once. Further parameters give the set value, the reset value and the start-up value. A separate active-low power-on reset forces the start-up value at any time. In asynchronous override mode each override passes through a synchroniser of two stages. Assertion of an override takes effect at once, but release is only seen after the synchroniser has drained, so the register comes out of an override cleanly on a clock edge.

Top module: `shreg_right`

## Requirements
- R1: While `por_n` is low, `q` equals INIT_VAL truncated to WIDTH bits. This takes effect at once, without a clock edge.
- R2: On an active edge with `en` high, the select at its load level and no override active, `q` takes the value of `par_d`.
- R3: On an active edge with `en` high, the select at its shift level and no override active, `q` becomes `{sdin, q[WIDTH-1:1]}`. For a 4-bit register, loading 10 and then shifting with `sdin`=0 gives 5, 2, 1, 0, 0. Loading 4 and then shifting with `sdin`=1 gives 10, 13, 14, 15, 15.
- R4: On an active edge with `en` low and no override active, `q` keeps its value whatever `ld_sh`, `sdin` and `par_d` are.
- R5: FALL_EDGE=0 makes the register act on the rising edge of `clk`. FALL_EDGE=1 makes it act on the falling edge, and a rising edge then leaves `q` unchanged.
- R6: LOAD_WHEN_HIGH=1 loads when `ld_sh` is 1 and shifts when it is 0. LOAD_WHEN_HIGH=0 loads when `ld_sh` is 0 and shifts when it is 1.
- R7: SR_ACTIVE_HIGH=1 makes `set_in` and `rst_in` active at 1. SR_ACTIVE_HIGH=0 makes them active at 0.
- R8: With SR_ASYNC=0, an active override changes `q` only on an active edge, not before it, and it takes priority over `en`, load and shift.
- R9: With SR_ASYNC=1, asserting an override changes `q` at once, with no clock edge. After release, the first SYNC_STAGES active edges still apply the override, and the following edge acts normally.
- R10: An active `set_in` gives `q` = SET_VAL, where -1 means all ones and any other value is truncated to WIDTH bits. An active `rst_in` gives `q` = RESET_VAL, where -1 or 0 means all zeros and any other value is truncated (17 in 4 bits gives 1).
- R11: When `set_in` and `rst_in` are active together, `q` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is chosen by FALL_EDGE |
| por_n | input | 1 | Active-low power-on reset to INIT_VAL |
| en | input | 1 | Enable for load and shift, active high |
| ld_sh | input | 1 | Load/shift select; polarity set by LOAD_WHEN_HIGH |
| sdin | input | 1 | Serial data entering the MSB on a shift |
| par_d | input | WIDTH | Parallel data for a load |
| set_in | input | 1 | Force-to-set-value override |
| rst_in | input | 1 | Force-to-reset-value override |
| q | output | WIDTH | Register contents |

## Verification
Two functions can fall in the same cycle. An override can coincide with a pending load or shift, and the two overrides can coincide with each other. The bench provokes the first by holding enable and a load word while an override is active, and requires the override value, never the load word. It provokes the second both at one synchronous edge and by raising one asynchronous override while the other is held, and requires the value from before the clash. The asynchronous instance is also checked for an immediate change between edges and for the override persisting through the drain edges after release.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_SHIFT,
        OP_FORCE_SET,
        OP_FORCE_CLR,
        OP_CONFLICT
    } shreg_op_e;

endpackage

// File: rtl/shreg_ctl_sync.sv
// Override synchroniser: assertion passes straight through, release drains
// through STAGES flops on the effective clock.
module shreg_ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_n,
    input  logic act_i,
    output logic lvl_o
);

    logic [STAGES-1:0] pipe_d;
    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES < 2) begin : g_bad_stages
            $error("shreg_ctl_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], 1'b0};
    end

    always_ff @(posedge clk_i or negedge por_n or posedge act_i) begin
        if (!por_n) begin
            pipe_q <= '0;
        end else if (act_i) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl_o = pipe_q[STAGES-1];

endmodule

// File: rtl/shreg_decode.sv
// Chooses the operation for the coming edge; overrides win, a clash holds.
module shreg_decode
    import shreg_pkg::*;
(
    input  logic      en_i,
    input  logic      load_sel_i,
    input  logic      set_i,
    input  logic      clr_i,
    output shreg_op_e op_o
);

    always_comb begin
        if (set_i && clr_i) begin
            op_o = OP_CONFLICT;
        end else if (set_i) begin
            op_o = OP_FORCE_SET;
        end else if (clr_i) begin
            op_o = OP_FORCE_CLR;
        end else if (!en_i) begin
            op_o = OP_HOLD;
        end else if (load_sel_i) begin
            op_o = OP_LOAD;
        end else begin
            op_o = OP_SHIFT;
        end
    end

endmodule

// File: rtl/shreg_datapath.sv
// Next-value mux for the register word.
module shreg_datapath
    import shreg_pkg::*;
#(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] SET_V = '1,
    parameter logic [WIDTH-1:0] CLR_V = '0
) (
    input  shreg_op_e        op_i,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             sdin_i,
    output logic [WIDTH-1:0] nxt_o
);

    always_comb begin
        unique case (op_i)
            OP_LOAD:      nxt_o = par_i;
            OP_SHIFT:     nxt_o = {sdin_i, cur_i[WIDTH-1:1]};
            OP_FORCE_SET: nxt_o = SET_V;
            OP_FORCE_CLR: nxt_o = CLR_V;
            default:      nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/shreg_right.sv
module shreg_right
    import shreg_pkg::*;
#(
    parameter int WIDTH          = 4,
    parameter int FALL_EDGE      = 0,
    parameter int LOAD_WHEN_HIGH = 1,
    parameter int SR_ACTIVE_HIGH = 1,
    parameter int SR_ASYNC       = 0,
    parameter int SET_VAL        = -1,
    parameter int RESET_VAL      = -1,
    parameter int INIT_VAL       = 0,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic             ld_sh,
    input  logic             sdin,
    input  logic [WIDTH-1:0] par_d,
    input  logic             set_in,
    input  logic             rst_in,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] SET_V  = (SET_VAL == -1) ? {WIDTH{1'b1}} : WIDTH'(SET_VAL);
    localparam logic [WIDTH-1:0] RST_V  = (RESET_VAL == -1) ? {WIDTH{1'b0}} : WIDTH'(RESET_VAL);
    localparam logic [WIDTH-1:0] INIT_V = WIDTH'(INIT_VAL);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;

    state_t    state_d;
    state_t    state_q;
    logic      clk_i;
    logic      load_sel;
    logic      set_act;
    logic      rst_act;
    logic      set_lvl;
    logic      rst_lvl;
    logic      set_dec;
    logic      rst_dec;
    shreg_op_e op;
    logic [WIDTH-1:0] nxt_word;

    generate
        if (WIDTH < 2) begin : g_bad_width
            $error("shreg_right needs WIDTH of at least 2");
        end
    endgenerate

    // effective clock and normalised control levels
    assign clk_i    = (FALL_EDGE != 0) ? ~clk : clk;
    assign load_sel = (LOAD_WHEN_HIGH != 0) ? ld_sh : ~ld_sh;
    assign set_act  = (SR_ACTIVE_HIGH != 0) ? set_in : ~set_in;
    assign rst_act  = (SR_ACTIVE_HIGH != 0) ? rst_in : ~rst_in;

    generate
        if (SR_ASYNC != 0) begin : g_async_ctl
            shreg_ctl_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
                .clk_i (clk_i),
                .por_n (por_n),
                .act_i (set_act),
                .lvl_o (set_lvl)
            );
            shreg_ctl_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
                .clk_i (clk_i),
                .por_n (por_n),
                .act_i (rst_act),
                .lvl_o (rst_lvl)
            );
            // overrides act on the flop's asynchronous branch only
            assign set_dec = 1'b0;
            assign rst_dec = 1'b0;
        end else begin : g_sync_ctl
            assign set_lvl = set_act;
            assign rst_lvl = rst_act;
            assign set_dec = set_lvl;
            assign rst_dec = rst_lvl;
        end
    endgenerate

    shreg_decode u_decode (
        .en_i       (en),
        .load_sel_i (load_sel),
        .set_i      (set_dec),
        .clr_i      (rst_dec),
        .op_o       (op)
    );

    shreg_datapath #(
        .WIDTH (WIDTH),
        .SET_V (SET_V),
        .CLR_V (RST_V)
    ) u_datapath (
        .op_i   (op),
        .cur_i  (state_q.word),
        .par_i  (par_d),
        .sdin_i (sdin),
        .nxt_o  (nxt_word)
    );

    always_comb begin
        state_d      = state_q;
        state_d.word = nxt_word;
    end

    generate
        if (SR_ASYNC != 0) begin : g_async_reg
            always_ff @(posedge clk_i or negedge por_n or posedge set_lvl or posedge rst_lvl) begin
                if (!por_n) begin
                    state_q.word <= INIT_V;
                end else if (set_lvl && rst_lvl) begin
                    state_q <= state_q;
                end else if (set_lvl) begin
                    state_q.word <= SET_V;
                end else if (rst_lvl) begin
                    state_q.word <= RST_V;
                end else begin
                    state_q <= state_d;
                end
            end
        end else begin : g_sync_reg
            always_ff @(posedge clk_i or negedge por_n) begin
                if (!por_n) begin
                    state_q.word <= INIT_V;
                end else begin
                    state_q <= state_d;
                end
            end
        end
    endgenerate

    assign q = state_q.word;

endmodule

// File: rtl/shreg_right_chk.sv
module shreg_right_chk #(
    parameter int               WIDTH    = 4,
    parameter int               SR_ASYNC = 0,
    parameter logic [WIDTH-1:0] SET_V    = '1,
    parameter logic [WIDTH-1:0] RST_V    = '0
) (
    input logic             clk_i,
    input logic             por_n,
    input logic             en,
    input logic             load_sel,
    input logic             sdin,
    input logic [WIDTH-1:0] par_d,
    input logic             set_lvl,
    input logic             rst_lvl,
    input logic [WIDTH-1:0] q
);

    // in asynchronous mode an override may strike between two edges
    logic late_ovr;
    assign late_ovr = (SR_ASYNC != 0) && (set_lvl || rst_lvl);

    assert_load_R2: assert property (@(posedge clk_i) disable iff (!por_n)
        (en && load_sel && !set_lvl && !rst_lvl) |=> (late_ovr || q == $past(par_d)));

    assert_shift_R3: assert property (@(posedge clk_i) disable iff (!por_n)
        (en && !load_sel && !set_lvl && !rst_lvl)
            |=> (late_ovr || q == {$past(sdin), $past(q[WIDTH-1:1])}));

    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!por_n)
        (!en && !set_lvl && !rst_lvl) |=> (late_ovr || $stable(q)));

    assert_set_value_R10: assert property (@(posedge clk_i) disable iff (!por_n)
        (set_lvl && !rst_lvl) |=> (q == SET_V));

    assert_reset_value_R10: assert property (@(posedge clk_i) disable iff (!por_n)
        (rst_lvl && !set_lvl) |=> (q == RST_V));

    assert_clash_hold_R11: assert property (@(posedge clk_i) disable iff (!por_n)
        (set_lvl && rst_lvl) |=> $stable(q));

endmodule

bind shreg_right shreg_right_chk #(
    .WIDTH    (WIDTH),
    .SR_ASYNC (SR_ASYNC),
    .SET_V    (SET_V),
    .RST_V    (RST_V)
) u_chk (
    .clk_i    (clk_i),
    .por_n    (por_n),
    .en       (en),
    .load_sel (load_sel),
    .sdin     (sdin),
    .par_d    (par_d),
    .set_lvl  (set_lvl),
    .rst_lvl  (rst_lvl),
    .q        (q)
);

// File: tb/shreg_right_tb.sv
module shreg_right_tb;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    always #10 clk = ~clk;

    // instance A: rising edge, load on 1, active-high synchronous overrides
    logic a_en = 1'b0, a_ld = 1'b1, a_sd = 1'b0, a_set = 1'b0, a_rst = 1'b0;
    logic [3:0] a_d = 4'd0;
    logic [3:0] a_q;

    // instance B: falling edge, load on 0, active-low asynchronous overrides
    logic b_en = 1'b0, b_ld = 1'b1, b_sd = 1'b0, b_set = 1'b1, b_rst = 1'b1;
    logic [3:0] b_d = 4'd0;
    logic [3:0] b_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    shreg_right #(
        .WIDTH(4), .FALL_EDGE(0), .LOAD_WHEN_HIGH(1), .SR_ACTIVE_HIGH(1),
        .SR_ASYNC(0), .SET_VAL(-1), .RESET_VAL(-1), .INIT_VAL(15)
    ) u_dut (
        .clk(clk), .por_n(por_n), .en(a_en), .ld_sh(a_ld), .sdin(a_sd),
        .par_d(a_d), .set_in(a_set), .rst_in(a_rst), .q(a_q)
    );

    shreg_right #(
        .WIDTH(4), .FALL_EDGE(1), .LOAD_WHEN_HIGH(0), .SR_ACTIVE_HIGH(0),
        .SR_ASYNC(1), .SET_VAL(11), .RESET_VAL(17), .INIT_VAL(5)
    ) u_dut_alt (
        .clk(clk), .por_n(por_n), .en(b_en), .ld_sh(b_ld), .sdin(b_sd),
        .par_d(b_d), .set_in(b_set), .rst_in(b_rst), .q(b_q)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick_a();
        @(posedge clk);
        #2;
    endtask

    task automatic tick_b();
        @(negedge clk);
        #2;
    endtask

    task automatic t_power_on();
        #25;
        chk("R1 start-up value A", a_q, 4'd15);
        chk("R1 start-up value B", b_q, 4'd5);
        por_n = 1'b1;
    endtask

    task automatic t_shift_zero();
        logic [3:0] exp_seq [5] = '{4'd5, 4'd2, 4'd1, 4'd0, 4'd0};
        @(negedge clk);
        a_en = 1'b1; a_ld = 1'b1; a_d = 4'd10;
        tick_a();
        chk("R2 load 10", a_q, 4'd10);
        a_ld = 1'b0; a_sd = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick_a();
            chk("R3 shift in 0", a_q, exp_seq[i]);
        end
    endtask

    task automatic t_shift_one();
        logic [3:0] exp_seq [5] = '{4'd10, 4'd13, 4'd14, 4'd15, 4'd15};
        a_ld = 1'b1; a_d = 4'd4;
        tick_a();
        chk("R2 load 4", a_q, 4'd4);
        a_en = 1'b0; a_ld = 1'b0; a_sd = 1'b1; a_d = 4'd9;
        tick_a();
        chk("R4 hold with shift level", a_q, 4'd4);
        a_ld = 1'b1;
        tick_a();
        chk("R4 hold with load level", a_q, 4'd4);
        a_en = 1'b1; a_ld = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick_a();
            chk("R3 R6 shift in 1", a_q, exp_seq[i]);
        end
    endtask

    task automatic t_sync_override();
        a_ld = 1'b1; a_d = 4'd9; a_rst = 1'b1;
        #3;
        chk("R8 no change before edge", a_q, 4'd15);
        tick_a();
        chk("R8 R10 reset beats load", a_q, 4'd0);
        a_rst = 1'b0; a_set = 1'b1; a_en = 1'b0;
        tick_a();
        chk("R7 R10 set to all ones", a_q, 4'd15);
        a_set = 1'b0; a_en = 1'b1; a_ld = 1'b1; a_d = 4'd6;
        tick_a();
        chk("R2 load 6", a_q, 4'd6);
        a_set = 1'b1; a_rst = 1'b1; a_d = 4'd9;
        tick_a();
        chk("R11 sync clash holds", a_q, 4'd6);
        a_set = 1'b0; a_rst = 1'b0;
        tick_a();
        chk("R2 load after clash", a_q, 4'd9);
    endtask

    task automatic t_edge_polarity();
        tick_b();
        b_en = 1'b1; b_ld = 1'b0; b_d = 4'd7;
        @(posedge clk);
        #2;
        chk("R5 rising edge ignored", b_q, 4'd5);
        tick_b();
        chk("R5 R6 load on falling edge with select 0", b_q, 4'd7);
        b_ld = 1'b1; b_sd = 1'b1;
        tick_b();
        chk("R3 R6 shift with select 1", b_q, 4'd11);
        b_sd = 1'b0;
        tick_b();
        chk("R3 shift in 0", b_q, 4'd5);
    endtask

    task automatic t_async_set();
        b_ld = 1'b0; b_d = 4'd2;
        tick_b();
        chk("R2 load 2", b_q, 4'd2);
        b_set = 1'b0;
        #1;
        chk("R7 R9 R10 immediate set", b_q, 4'd11);
        tick_b();
        chk("R9 set beats load", b_q, 4'd11);
        b_set = 1'b1; b_d = 4'd3;
        tick_b();
        chk("R9 drain edge 1", b_q, 4'd11);
        tick_b();
        chk("R9 drain edge 2", b_q, 4'd11);
        tick_b();
        chk("R9 normal after drain", b_q, 4'd3);
    endtask

    task automatic t_async_reset();
        b_rst = 1'b0;
        #1;
        chk("R9 R10 immediate reset truncated", b_q, 4'd1);
        b_rst = 1'b1; b_d = 4'd6;
        tick_b();
        chk("R9 reset drain edge 1", b_q, 4'd1);
        tick_b();
        chk("R9 reset drain edge 2", b_q, 4'd1);
        tick_b();
        chk("R9 load after reset", b_q, 4'd6);
    endtask

    task automatic t_async_clash();
        b_set = 1'b0;
        #1;
        chk("R9 set before clash", b_q, 4'd11);
        b_rst = 1'b0;
        #1;
        chk("R11 async clash holds", b_q, 4'd11);
        tick_b();
        chk("R11 clash holds at edge", b_q, 4'd11);
        b_set = 1'b1; b_rst = 1'b1; b_d = 4'd12;
        tick_b();
        chk("R11 clash drain edge 1", b_q, 4'd11);
        tick_b();
        chk("R11 clash drain edge 2", b_q, 4'd11);
        tick_b();
        chk("R2 load after clash", b_q, 4'd12);
    endtask

    task automatic t_power_on_again();
        por_n = 1'b0;
        #1;
        chk("R1 immediate power-on A", a_q, 4'd15);
        chk("R1 immediate power-on B", b_q, 4'd5);
        tick_a();
        chk("R1 held during power-on", a_q, 4'd15);
        por_n = 1'b1;
    endtask

    initial begin
        t_power_on();
        t_shift_zero();
        t_shift_one();
        t_sync_override();
        t_edge_polarity();
        t_async_set();
        t_async_reset();
        t_async_clash();
        t_power_on_again();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule